// File: doc/BRIEF.md
# Compare-Guarded Interrupt Status Register Block

This block sits on a small byte-wide control bus and keeps an 8-bit interrupt status register, an interrupt mask and a set of compare registers. Pulses from neighbouring logic (user sense, two receive conditions, link error counter expiry, request-data parity faults) set status bits. Software clears them by writing the register. The block also checks parity on every write and flags writes to addresses that cannot be written. A single interrupt output is raised while any unmasked status bit is set.

Four registers are guarded: the status register, a transmit control register and two receive condition registers. Each guarded register has its own compare register. A write to a guarded register takes effect only when the register's present contents equal its compare register. Software first copies what it read into the compare register and then writes the cleared value. If an event arrived in between, the contents no longer match, so the write is refused and the inhibit flag is raised. A fresh event is therefore never erased unseen.

Top module: `cw_intr_regs`

## Requirements
- R1: After reset every register reads 0 and `irq` is 0.
- R2: `irq` is 1 exactly when some bit of the status register (address 02h) is 1 and the same bit of the mask register (address 03h) is 1.
- R3: A pulse on `ev_user`, `ev_rxb`, `ev_rxa` or `ev_link` sets status bit 7, 6, 5 or 4 respectively.
- R4: Status bit 0 is set by `req_par_err` only while bit 0 of the transmit control register (address 04h) is 1.
- R5: Write parity is odd over `wdata` and `wpar`. When `bus_par_en` is 1 and a write has an even count of ones, status bit 1 is set and no register is written. When `bus_par_en` is 0, no parity check is made.
- R6: A parity-clean write to any address outside {02h, 03h, 04h, 09h, 0Ah, 1Ah..1Dh} sets status bit 2 and changes no other register.
- R7: A write to a guarded register (02h, 04h, 09h, 0Ah, with compare registers at 1Ah, 1Bh, 1Ch, 1Dh in that order) loads `wdata` only if the register equals its compare register. Otherwise the register keeps its value and status bit 3 is set.
- R8: Status bit 3 stays 1 until a successful write to the status register clears it.
- R9: When an event pulse and an accepted status write that clears the same bit fall in one cycle, the bit ends at 1.
- R10: The mask and compare registers are plain read/write registers. `rdata` shows the register at `addr`, and an unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | 5 | Register address for read and write |
| wdata | input | 8 | Write data |
| wpar | input | 1 | Odd parity bit for `wdata` |
| bus_par_en | input | 1 | Enables the write parity check |
| rdata | output | 8 | Read data for `addr` |
| ev_user | input | 1 | User sense event pulse |
| ev_rxb | input | 1 | Receive condition B event pulse |
| ev_rxa | input | 1 | Receive condition A event pulse |
| ev_link | input | 1 | Link error counter expiry pulse |
| req_par_err | input | 1 | Parity fault seen on request data |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `wr_en` and the event inputs are 0 while `rst_n` is low. They also assume that every input is sampled as a settled level at the rising edge, with no glitches. The bench changes inputs only half a period away from the rising edge and holds everything at 0 during reset. It sweeps every status value against a range of masks, every address for write rejection, every write data value for parity, and each guarded register with matching and mismatching compares.

// File: rtl/cwr_pkg.sv
// Package: constants shared by the compare-guarded status register block.
// Assumes a 5-bit address space and an 8-bit data path.
package cwr_pkg;
    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 8;
    localparam int NGUARD  = 4;
    localparam int EV_W    = 4;

    localparam logic [ADDR_W-1:0] A_STATUS   = 5'h02;
    localparam logic [ADDR_W-1:0] A_MASK     = 5'h03;
    localparam logic [ADDR_W-1:0] A_XMIT     = 5'h04;
    localparam logic [ADDR_W-1:0] A_RXA      = 5'h09;
    localparam logic [ADDR_W-1:0] A_RXB      = 5'h0A;
    localparam logic [ADDR_W-1:0] A_CMP_BASE = 5'h1A;

    // status bit positions
    localparam int B_REQPAR  = 0;
    localparam int B_BUSPAR  = 1;
    localparam int B_REJECT  = 2;
    localparam int B_INHIBIT = 3;
    localparam int B_EV_LO   = 4;   // events occupy bits 4..7

    // guarded register index to address
    function automatic logic [ADDR_W-1:0] guard_addr(input int idx);
        case (idx)
            0:       return A_STATUS;
            1:       return A_XMIT;
            2:       return A_RXA;
            default: return A_RXB;
        endcase
    endfunction
endpackage

// File: rtl/cwr_decode.sv
// Write decoder: checks odd write parity, turns a clean write into one
// strobe per writable register, and flags writes to any other address.
// Assumes wr_en is a single-cycle strobe with addr/wdata valid alongside.
module cwr_decode
    import cwr_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wpar,
    input  logic              bus_par_en,
    output logic              par_err,
    output logic              reject,
    output logic              wr_mask,
    output logic [NGUARD-1:0] wr_guard,
    output logic [NGUARD-1:0] wr_cmp
);
    logic wr_ok;

    // parity qualification: odd count of ones over data plus parity is good
    always_comb begin
        par_err = wr_en & bus_par_en & ~(^{wdata, wpar});
        wr_ok   = wr_en & ~par_err;
    end

    // per-register strobes
    for (genvar i = 0; i < NGUARD; i++) begin : g_strobe
        assign wr_guard[i] = wr_ok && (addr == guard_addr(i));
        assign wr_cmp[i]   = wr_ok && (addr == A_CMP_BASE + ADDR_W'(i));
    end

    // mask strobe and reject for unmapped targets
    always_comb begin
        wr_mask = wr_ok && (addr == A_MASK);
        reject  = wr_ok && !(wr_mask || (|wr_guard) || (|wr_cmp));
    end
endmodule

// File: rtl/cwr_guard_reg.sv
// Guarded register with its compare register. A value write is accepted
// only when value equals compare; set_bits are ORed in after any write.
// Assumes wr_val and wr_cmp are never both high (distinct addresses).
module cwr_guard_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_val,
    input  logic         wr_cmp,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] set_bits,
    output logic [W-1:0] value,
    output logic [W-1:0] cmp,
    output logic         blocked
);
    logic [W-1:0] base;

    // compare gate and write selection
    always_comb begin
        blocked = wr_val && (value != cmp);
        base    = (wr_val && !blocked) ? wdata : value;
    end

    // value register: write result with events taking priority
    always_ff @(posedge clk) begin
        if (!rst_n) value <= '0;
        else        value <= base | set_bits;
    end

    // compare register: plain read/write
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp <= '0;
        else if (wr_cmp) cmp <= wdata;
    end

    // R7
    blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |=> value == ($past(value) | $past(set_bits)));

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_bits) |=> (value & $past(set_bits)) == $past(set_bits));
endmodule

// File: rtl/cwr_irq_ctl.sv
// Builds the status set vector from events and write faults, holds the
// interrupt mask, and raises irq on any unmasked status bit.
// Assumes event inputs are single-cycle pulses from synchronous logic.
module cwr_irq_ctl
    import cwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_mask,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] status,
    input  logic [EV_W-1:0]   events,
    input  logic              req_par_err,
    input  logic              req_par_en,
    input  logic              par_err,
    input  logic              reject,
    input  logic              blocked_any,
    output logic [DATA_W-1:0] set_bits,
    output logic [DATA_W-1:0] mask,
    output logic              irq
);
    // set vector assembly
    always_comb begin
        set_bits = '0;
        set_bits[B_EV_LO +: EV_W] = events;
        set_bits[B_INHIBIT]       = blocked_any;
        set_bits[B_REJECT]        = reject;
        set_bits[B_BUSPAR]        = par_err;
        set_bits[B_REQPAR]        = req_par_err & req_par_en;
    end

    // mask register: plain read/write
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (wr_mask) mask <= wdata;
    end

    // interrupt output
    always_comb irq = |(status & mask);

    // R5
    par_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |=> $stable(mask));

    // R2
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);
endmodule

// File: rtl/cw_intr_regs.sv
// Top: compare-guarded interrupt status register block. Ties decoder,
// four guarded registers and the interrupt control together and muxes reads.
// Assumes inputs are held low during reset and change away from clk edges.
module cw_intr_regs
    import cwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wpar,
    input  logic              bus_par_en,
    output logic [DATA_W-1:0] rdata,
    input  logic              ev_user,
    input  logic              ev_rxb,
    input  logic              ev_rxa,
    input  logic              ev_link,
    input  logic              req_par_err,
    output logic              irq
);
    logic              par_err, reject, wr_mask;
    logic [NGUARD-1:0] wr_guard, wr_cmp, blocked;
    logic [DATA_W-1:0] gval [NGUARD];
    logic [DATA_W-1:0] gcmp [NGUARD];
    logic [DATA_W-1:0] set_bits, mask;

    cwr_decode u_dec (
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .wpar(wpar),
        .bus_par_en(bus_par_en), .par_err(par_err), .reject(reject),
        .wr_mask(wr_mask), .wr_guard(wr_guard), .wr_cmp(wr_cmp)
    );

    // guarded registers: index 0 is the status register and takes set bits
    for (genvar i = 0; i < NGUARD; i++) begin : g_guard
        cwr_guard_reg #(.W(DATA_W)) u_reg (
            .clk(clk), .rst_n(rst_n), .wr_val(wr_guard[i]), .wr_cmp(wr_cmp[i]),
            .wdata(wdata), .set_bits((i == 0) ? set_bits : '0),
            .value(gval[i]), .cmp(gcmp[i]), .blocked(blocked[i])
        );
    end

    cwr_irq_ctl u_irq (
        .clk(clk), .rst_n(rst_n), .wr_mask(wr_mask), .wdata(wdata),
        .status(gval[0]), .events({ev_user, ev_rxb, ev_rxa, ev_link}),
        .req_par_err(req_par_err), .req_par_en(gval[1][0]),
        .par_err(par_err), .reject(reject), .blocked_any(|blocked),
        .set_bits(set_bits), .mask(mask), .irq(irq)
    );

    // read multiplexer
    always_comb begin
        rdata = '0;
        if (addr == A_MASK) rdata = mask;
        for (int i = 0; i < NGUARD; i++) begin
            if (addr == guard_addr(i))              rdata = gval[i];
            if (addr == A_CMP_BASE + ADDR_W'(i))    rdata = gcmp[i];
        end
    end

    // R8
    inhibit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gval[0][B_INHIBIT] && !wr_guard[0]) |=> gval[0][B_INHIBIT]);

    // R6
    reject_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> gval[0][B_REJECT] && $stable(mask));

    // R5
    parerr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |=> gval[0][B_BUSPAR]);
endmodule

// File: tb/cw_intr_regs_bench.sv
module cw_intr_regs_bench;
    localparam int CLK_P = 10;

    logic       clk = 0, rst_n = 0;
    logic       wr_en = 0, wpar = 0, bus_par_en = 0;
    logic [4:0] addr = 0;
    logic [7:0] wdata = 0, rdata;
    logic       ev_user = 0, ev_rxb = 0, ev_rxa = 0, ev_link = 0, req_par_err = 0;
    logic       irq;

    int tests = 0, fails = 0;
    logic [7:0] mg [4];
    logic [7:0] mc [4];
    logic [7:0] mm;

    always #(CLK_P/2) clk = ~clk;

    cw_intr_regs u_cw_intr_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .wpar(wpar), .bus_par_en(bus_par_en), .rdata(rdata),
        .ev_user(ev_user), .ev_rxb(ev_rxb), .ev_rxa(ev_rxa), .ev_link(ev_link),
        .req_par_err(req_par_err), .irq(irq)
    );

    function automatic int gidx(input logic [4:0] a);
        case (a)
            5'h02: return 0;
            5'h04: return 1;
            5'h09: return 2;
            5'h0A: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic logic [7:0] model_read(input logic [4:0] a);
        if (a == 5'h03) return mm;
        if (gidx(a) >= 0) return mg[gidx(a)];
        if (a >= 5'h1A && a <= 5'h1D) return mc[a - 5'h1A];
        return 8'h00;
    endfunction

    // one bus cycle; model updated from the requirements
    task automatic cyc(input bit wr, input logic [4:0] a, input logic [7:0] d,
                       input bit good, input bit pen, input logic [3:0] ev, input bit rq);
        logic [7:0] ng [4];
        logic [7:0] nc [4];
        logic [7:0] nm, sets;
        @(negedge clk);
        wr_en = wr; addr = a; wdata = d; wpar = good ? ~^d : ^d; bus_par_en = pen;
        {ev_user, ev_rxb, ev_rxa, ev_link} = ev; req_par_err = rq;
        ng = mg; nc = mc; nm = mm; sets = 0;
        if (wr && pen && !good) sets[1] = 1;
        else if (wr) begin
            if (a == 5'h03) nm = d;
            else if (a >= 5'h1A && a <= 5'h1D) nc[a - 5'h1A] = d;
            else if (gidx(a) >= 0) begin
                if (mg[gidx(a)] == mc[gidx(a)]) ng[gidx(a)] = d;
                else sets[3] = 1;
            end else sets[2] = 1;
        end
        sets[7:4] = sets[7:4] | ev;
        if (rq && mg[1][0]) sets[0] = 1;
        ng[0] = ng[0] | sets;
        @(posedge clk);
        mg = ng; mc = nc; mm = nm;
        #1;
        wr_en = 0; bus_par_en = 0; {ev_user, ev_rxb, ev_rxa, ev_link} = 0; req_par_err = 0;
    endtask

    task automatic wr_ok(input logic [4:0] a, input logic [7:0] d);
        cyc(1, a, d, 1, 1, 4'b0, 0);
    endtask

    task automatic chk(input string tag, input string what, input logic [7:0] got, input logic [7:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    task automatic check_irq(input string tag);
        @(negedge clk); #1;
        chk(tag, "irq", {7'b0, irq}, {7'b0, |(mg[0] & mm)});
    endtask

    task automatic check_all(input string tag);
        @(negedge clk);
        for (int a = 0; a < 32; a++) begin
            addr = 5'(a); #1;
            chk(tag, $sformatf("rdata[%0h]", a), rdata, model_read(5'(a)));
        end
        chk(tag, "irq", {7'b0, irq}, {7'b0, |(mg[0] & mm)});
    endtask

    task automatic clear_status();
        wr_ok(5'h1A, mg[0]);
        wr_ok(5'h02, 8'h00);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin mg[i] = 0; mc[i] = 0; end
        mm = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        check_all("R1");

        // R2 status sweep against mask patterns
        for (int m = 0; m < 16; m++) begin
            wr_ok(5'h03, (m == 15) ? 8'hFF : (8'h01 << (m % 8)) ^ ((m >= 8) ? 8'hA5 : 8'h00));
            for (int v = 0; v < 256; v++) begin
                wr_ok(5'h1A, mg[0]);
                wr_ok(5'h02, 8'(v));
                check_irq("R2");
            end
        end
        wr_ok(5'h03, 8'h00);
        check_all("R2");

        // R3 each event alone
        for (int e = 0; e < 4; e++) begin
            clear_status();
            cyc(0, 5'h00, 8'h00, 1, 0, 4'(1 << e), 0);
            check_all("R3");
        end

        // R4 request parity gated by transmit enable bit
        clear_status();
        cyc(0, 5'h00, 8'h00, 1, 0, 4'b0, 1);
        check_all("R4");
        wr_ok(5'h04, 8'h01);
        cyc(0, 5'h00, 8'h00, 1, 0, 4'b0, 1);
        check_all("R4");

        // R5 parity sweep on mask writes
        for (int d = 0; d < 256; d++) begin
            cyc(1, 5'h03, 8'(d), d[0], 1, 4'b0, 0);
            @(negedge clk); addr = 5'h03; #1;
            chk("R5", "mask", rdata, mm);
        end
        cyc(1, 5'h03, 8'h3C, 0, 0, 4'b0, 0);
        check_all("R5");

        // R6 writes to every address, clean parity
        for (int a = 0; a < 32; a++) begin
            clear_status();
            if (gidx(5'(a)) < 0 && !(a >= 26 && a <= 29) && a != 3) begin
                wr_ok(5'(a), 8'hE7);
                check_all("R6");
            end
        end

        // R7 mismatched and matched compares on each guarded register
        for (int g = 1; g < 4; g++) begin
            logic [4:0] ga;
            ga = (g == 1) ? 5'h04 : (g == 2) ? 5'h09 : 5'h0A;
            wr_ok(5'h1A + 5'(g), mg[g] ^ 8'h5A);
            wr_ok(ga, 8'hFF);
            check_all("R7");
            wr_ok(5'h1A + 5'(g), mg[g]);
            wr_ok(ga, 8'h00);
            check_all("R7");
        end

        // R8 inhibit stays until cleared
        clear_status();
        wr_ok(5'h1A, 8'h01);
        wr_ok(5'h02, 8'h00);
        repeat (5) cyc(0, 5'h00, 8'h00, 1, 0, 4'b0, 0);
        check_all("R8");
        clear_status();
        check_all("R8");

        // R9 event and clearing write collide
        wr_ok(5'h1A, mg[0]);
        cyc(1, 5'h02, 8'h00, 1, 1, 4'b1000, 0);
        check_all("R9");

        // R10 mask and compare read/write, unmapped reads 0
        for (int i = 0; i < 4; i++) wr_ok(5'h1A + 5'(i), 8'h11 * 8'(i + 3));
        wr_ok(5'h03, 8'hC3);
        check_all("R10");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule